// File: doc/BRIEF.md
# Byte-Lane Host Register Bridge

This block sits between a narrow host I/O bus and the acquisition logic of a small data-capture peripheral. It claims a 32-byte window of I/O space whose base is picked by two jumper inputs. Inside that window it holds the configuration, pacing and interrupt-threshold registers. It returns an identity word, and it serves reads of the sample FIFO's head word.

Every register is 16 bits wide. A wide host reaches a register in one 16-bit cycle. An 8-bit host reaches it with two byte cycles on consecutive clocks, the low byte first. The bridge holds the low byte until the high byte arrives, so a register never changes halfway. A FIFO word can be read whole or as two bytes. The FIFO is popped by the whole-word read or by the high-byte read, so a split read consumes the entry only once. Each FIFO read access also gives a one-cycle pulse, which can drive an activity indicator.

Top module: `hostRegBridge`

## Requirements
- R1: The window base is 0x100 plus 0x20 times `jumpers[1:0]`, so the four settings give 0x100, 0x120, 0x140 and 0x160. The word index is `busAddr[4:1]`. A word access (`busByteEn`=11) or a low-byte access (01) needs `busAddr[0]`=0. A high-byte access (10) needs `busAddr[0]`=1. An access outside the window, or with any other combination, reads zero, pops nothing and writes nothing.
- R2: A read at index 0 returns {`jumpers[3:0]`, revision (parameter, default 1), 0x3F} in bits 15-12, 11-8 and 7-0.
- R3: A 16-bit write takes effect at the next clock edge, and the registers read back as follows:
  - Index 1 (configuration) stores bits 8-0. Its bits 15-9 read zero. `runCmd` is bit 0 and `chanGroups` is bits 4-1.
  - Index 2 holds pacing bits 23-16 in its low byte, and its high byte reads zero.
  - Index 3 holds pacing bits 15-0.
  - A pacing register changes only at a clock edge that follows a write cycle.
- R4: A low-byte write to index 1-4 is staged. It is committed together with a high-byte write to the same index in the next clock cycle. A staged byte is discarded if that next cycle is anything else. A high-byte write with no matching staged byte is ignored.
- R5: Index 5 (byte 0x0A) returns the FIFO head word and pops it. Byte 0x1A returns the head's low byte in lane 7-0 and does not pop. Byte 0x1B returns the head's high byte in lane 15-8 and pops it. `fifoPop` is asserted in the same cycle as the read strobe.
- R6: Index 4 reads back as {FIFO count, head channel, interrupt enable} in bits 15-6, 5-1 and 0. A write to it sets the interrupt threshold from bits 15-6 and the enable from bit 0. The write leaves the count unchanged. After reset the threshold is 256 and the enable is 0.
- R7: `singleEnded` is configuration bit 8 OR bit 5. It is 1 after reset.
- R8: `inputRange2x` is 0 only when configuration bits 7-6 are 00. It is 1 after reset.
- R9: `ledPulse` is high during every FIFO read access, whether it is a word read, a low-byte read or a high-byte read.
- R10: The indices not named above read zero and ignore writes.
- R11: `irqLineSel` follows `jumpers[3]`.
- R12: Read data is registered. It appears on `busRdData` after the clock edge that samples `busRd`, in the lanes that `busByteEn` selects, and the other lane reads zero. When no read was sampled, `busRdData` is zero. After reset it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jumpers | input | 4 | Jumper states; bits 1-0 pick the base, bit 3 picks the interrupt line |
| busAddr | input | ADDR_W (10) | Host byte address |
| busByteEn | input | 2 | Byte lanes: 11 word, 01 low byte, 10 high byte |
| busWrData | input | 16 | Write data, in the lane of each byte |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRdData | output | 16 | Registered read data |
| fifoData | input | 16 | FIFO head word |
| fifoCount | input | CNT_W (10) | FIFO fill count |
| headChan | input | HEAD_W (5) | Channel of the FIFO head |
| fifoPop | output | 1 | Pops the FIFO head |
| ledPulse | output | 1 | High during any FIFO read access |
| irqLineSel | output | 1 | Selects the interrupt line |
| runCmd | output | 1 | Run command from the configuration register |
| chanGroups | output | 4 | Number of channel groups per scan |
| singleEnded | output | 1 | Single-ended input mode |
| inputRange2x | output | 1 | Double-reference input range |
| pacing | output | 24 | Pacing interval in clocks |
| irqThreshold | output | CNT_W (10) | FIFO count that raises the interrupt |
| irqEnable | output | 1 | Interrupt enable |

## Verification
The assertions check on every cycle that:
- a pop happens only on an in-window read of a kind that may pop, and that each pop also raises the activity pulse;
- idle cycles and out-of-window reads return zero;
- the identity byte is returned;
- the pacing value moves only after write cycles.

Only the bench's scenarios can show the rest:
- that a staged low byte merges with its high byte, and that it is dropped after a gap, a lone high byte or a switch to another register;
- the OR and decode rules of the mode outputs;
- the four jumper-selected windows.

// File: rtl/hostRegPkg.sv
package hostRegPkg;

  typedef enum logic [3:0] {
    IDX_ID        = 4'd0,
    IDX_CFG       = 4'd1,
    IDX_PACE_HI   = 4'd2,
    IDX_PACE_LO   = 4'd3,
    IDX_STAT      = 4'd4,
    IDX_FIFO_WORD = 4'd5,
    IDX_FIFO_BYTE = 4'd13
  } regIdx_e;

  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LOW  = 2'b01,
    LANE_HIGH = 2'b10,
    LANE_WORD = 2'b11
  } lane_e;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic        wrCommit;
    logic [3:0]  wrIdx;
    logic [15:0] wrWord;
    logic        rdEn;
    logic [3:0]  rdIdx;
    logic [1:0]  rdLanes;
  } busStrobe_t;

  function automatic logic isWritable(input logic [3:0] idx);
    return (idx == IDX_CFG) || (idx == IDX_PACE_HI) ||
           (idx == IDX_PACE_LO) || (idx == IDX_STAT);
  endfunction

endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int unsigned BASE_ROOT = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        jumperSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busByteEn,
  input  logic [15:0]       busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output busStrobe_t        strobe,
  output logic              fifoPop,
  output logic              ledPulse
);

  localparam int WIN_W = ADDR_W - 5;
  localparam logic [WIN_W-1:0] WIN_ROOT = WIN_W'(BASE_ROOT >> 5);

  logic [WIN_W-1:0] winBase;
  logic             inWin;
  logic             laneLegal;
  logic             hit;
  logic [3:0]       offIdx;
  logic             wordAcc;
  logic             lowAcc;
  logic             highAcc;

  logic             stageValid;
  logic [3:0]       stageIdx;
  logic [7:0]       stageByte;
  logic             pairHit;
  logic             wordWrite;

  assign winBase = WIN_ROOT + WIN_W'(jumperSel);
  assign inWin   = (busAddr[ADDR_W-1:5] == winBase);
  assign offIdx  = busAddr[4:1];
  assign wordAcc = (busByteEn == LANE_WORD);
  assign lowAcc  = (busByteEn == LANE_LOW);
  assign highAcc = (busByteEn == LANE_HIGH);

  // The lane must agree with the byte address.
  always_comb begin
    unique case (busByteEn)
      LANE_WORD: laneLegal = ~busAddr[0];
      LANE_LOW:  laneLegal = ~busAddr[0];
      LANE_HIGH: laneLegal = busAddr[0];
      default:   laneLegal = 1'b0;
    endcase
  end

  assign hit = inWin && laneLegal;

  // The low byte of a split write waits here for exactly one cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageIdx   <= '0;
      stageByte  <= '0;
    end else begin
      stageValid <= busWr && hit && lowAcc && isWritable(offIdx);
      stageIdx   <= offIdx;
      stageByte  <= busWrData[7:0];
    end
  end

  assign pairHit   = busWr && hit && highAcc && stageValid && (stageIdx == offIdx);
  assign wordWrite = busWr && hit && wordAcc && isWritable(offIdx);

  always_comb begin
    strobe.wrCommit = wordWrite || pairHit;
    strobe.wrIdx    = offIdx;
    strobe.wrWord   = pairHit ? {busWrData[15:8], stageByte} : busWrData;
    strobe.rdEn     = busRd && hit;
    strobe.rdIdx    = offIdx;
    strobe.rdLanes  = busByteEn;
  end

  // The word read and the high-byte read pop. The low-byte read does not.
  always_comb begin
    fifoPop  = 1'b0;
    ledPulse = 1'b0;
    if (busRd && hit) begin
      if (offIdx == IDX_FIFO_WORD) begin
        ledPulse = 1'b1;
        fifoPop  = wordAcc;
      end else if (offIdx == IDX_FIFO_BYTE) begin
        ledPulse = 1'b1;
        fifoPop  = highAcc;
      end
    end
  end

endmodule

// File: rtl/hostRegData.sv
module hostRegData
  import hostRegPkg::*;
#(
  parameter int         FIFO_DEPTH = 512,
  parameter logic [3:0] REV        = 4'h1,
  parameter int         CNT_W      = $clog2(FIFO_DEPTH) + 1,
  parameter int         HEAD_W     = 15 - CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [3:0]        jumpers,
  input  logic [15:0]       fifoData,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [HEAD_W-1:0] headChan,
  output logic [15:0]       busRdData,
  output logic              runCmd,
  output logic [3:0]        chanGroups,
  output logic              singleEnded,
  output logic              inputRange2x,
  output logic [23:0]       pacing,
  output logic [CNT_W-1:0]  irqThreshold,
  output logic              irqEnable
);

  localparam logic [7:0]       ID_CODE    = 8'h3F;
  localparam logic [8:0]       CFG_RESET  = 9'h160;
  localparam logic [CNT_W-1:0] THR_RESET  = CNT_W'(FIFO_DEPTH / 2);

  logic [8:0]       cfgReg;
  logic [7:0]       paceHiReg;
  logic [15:0]      paceLoReg;
  logic [CNT_W-1:0] thrReg;
  logic             irqEnReg;
  logic [15:0]      rdWord;
  logic [15:0]      rdMasked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= CFG_RESET;
      paceHiReg <= '0;
      paceLoReg <= '0;
      thrReg    <= THR_RESET;
      irqEnReg  <= 1'b0;
    end else if (strobe.wrCommit) begin
      unique case (strobe.wrIdx)
        IDX_CFG:     cfgReg    <= strobe.wrWord[8:0];
        IDX_PACE_HI: paceHiReg <= strobe.wrWord[7:0];
        IDX_PACE_LO: paceLoReg <= strobe.wrWord;
        IDX_STAT: begin
          thrReg   <= strobe.wrWord[15:16-CNT_W];
          irqEnReg <= strobe.wrWord[0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (strobe.rdIdx)
      IDX_ID:        rdWord = {jumpers, REV, ID_CODE};
      IDX_CFG:       rdWord = {7'd0, cfgReg};
      IDX_PACE_HI:   rdWord = {8'd0, paceHiReg};
      IDX_PACE_LO:   rdWord = paceLoReg;
      IDX_STAT:      rdWord = {fifoCount, headChan, irqEnReg};
      IDX_FIFO_WORD: rdWord = fifoData;
      IDX_FIFO_BYTE: rdWord = fifoData;
      default:       rdWord = '0;
    endcase
  end

  assign rdMasked = {strobe.rdLanes[1] ? rdWord[15:8] : 8'd0,
                     strobe.rdLanes[0] ? rdWord[7:0]  : 8'd0};

  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= strobe.rdEn ? rdMasked : 16'd0;
  end

  assign runCmd       = cfgReg[0];
  assign chanGroups   = cfgReg[4:1];
  assign singleEnded  = cfgReg[8] | cfgReg[5];
  assign inputRange2x = |cfgReg[7:6];
  assign pacing       = {paceHiReg, paceLoReg};
  assign irqThreshold = thrReg;
  assign irqEnable    = irqEnReg;

endmodule

// File: rtl/hostRegBridge.sv
module hostRegBridge
  import hostRegPkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter int unsigned BASE_ROOT  = 'h100,
  parameter int          FIFO_DEPTH = 512,
  parameter logic [3:0]  REV        = 4'h1,
  localparam int         CNT_W      = $clog2(FIFO_DEPTH) + 1,
  localparam int         HEAD_W     = 15 - CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        jumpers,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busByteEn,
  input  logic [15:0]       busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [15:0]       busRdData,
  input  logic [15:0]       fifoData,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [HEAD_W-1:0] headChan,
  output logic              fifoPop,
  output logic              ledPulse,
  output logic              irqLineSel,
  output logic              runCmd,
  output logic [3:0]        chanGroups,
  output logic              singleEnded,
  output logic              inputRange2x,
  output logic [23:0]       pacing,
  output logic [CNT_W-1:0]  irqThreshold,
  output logic              irqEnable
);

  busStrobe_t strobe;

  hostRegCtrl #(
    .ADDR_W    (ADDR_W),
    .BASE_ROOT (BASE_ROOT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .jumperSel (jumpers[1:0]),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWrData (busWrData),
    .busRd     (busRd),
    .busWr     (busWr),
    .strobe    (strobe),
    .fifoPop   (fifoPop),
    .ledPulse  (ledPulse)
  );

  hostRegData #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .REV        (REV),
    .CNT_W      (CNT_W),
    .HEAD_W     (HEAD_W)
  ) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .jumpers      (jumpers),
    .fifoData     (fifoData),
    .fifoCount    (fifoCount),
    .headChan     (headChan),
    .busRdData    (busRdData),
    .runCmd       (runCmd),
    .chanGroups   (chanGroups),
    .singleEnded  (singleEnded),
    .inputRange2x (inputRange2x),
    .pacing       (pacing),
    .irqThreshold (irqThreshold),
    .irqEnable    (irqEnable)
  );

  assign irqLineSel = jumpers[3];

endmodule

// File: rtl/hostRegChecker.sv
module hostRegChecker #(
  parameter int          ADDR_W    = 10,
  parameter int unsigned BASE_ROOT = 'h100
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        jumperSel,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busByteEn,
  input logic              busRd,
  input logic              busWr,
  input logic [15:0]       busRdData,
  input logic              fifoPop,
  input logic              ledPulse,
  input logic [23:0]       pacing
);

  localparam int WIN_W = ADDR_W - 5;
  logic [WIN_W-1:0] winBase;
  logic             inWin;

  assign winBase = WIN_W'(BASE_ROOT >> 5) + WIN_W'(jumperSel);
  assign inWin   = (busAddr[ADDR_W-1:5] == winBase);

  assert_pop_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (busRd && inWin && busByteEn != 2'b01 && busByteEn != 2'b00));

  assert_led_on_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> ledPulse);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdData == 16'h0000));

  assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !inWin) |=> (busRdData == 16'h0000));

  assert_id_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && inWin && busAddr[4:0] == 5'd0 && busByteEn == 2'b11)
      |=> (busRdData[7:0] == 8'h3F));

  assert_pacing_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(pacing));

endmodule

bind hostRegBridge hostRegChecker #(
  .ADDR_W    (ADDR_W),
  .BASE_ROOT (BASE_ROOT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .jumperSel (jumpers[1:0]),
  .busAddr   (busAddr),
  .busByteEn (busByteEn),
  .busRd     (busRd),
  .busWr     (busWr),
  .busRdData (busRdData),
  .fifoPop   (fifoPop),
  .ledPulse  (ledPulse),
  .pacing    (pacing)
);

// File: tb/hostRegBridge_tb.sv
module hostRegBridge_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  jumpers = 4'b0000;
  logic [9:0]  busAddr = '0;
  logic [1:0]  busByteEn = '0;
  logic [15:0] busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busRdData;
  logic [15:0] fifoData = 16'hA5C3;
  logic [9:0]  fifoCount = 10'd300;
  logic [4:0]  headChan = 5'd7;
  logic        fifoPop, ledPulse, irqLineSel, runCmd;
  logic [3:0]  chanGroups;
  logic        singleEnded, inputRange2x, irqEnable;
  logic [23:0] pacing;
  logic [9:0]  irqThreshold;

  int checks = 0;
  int fails = 0;
  logic popSeen, ledSeen;
  logic done = 1'b0;

  always #10 clk = ~clk;

  hostRegBridge dut_i (
    .clk(clk), .rstN(rstN), .jumpers(jumpers), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRd(busRd), .busWr(busWr),
    .busRdData(busRdData), .fifoData(fifoData), .fifoCount(fifoCount),
    .headChan(headChan), .fifoPop(fifoPop), .ledPulse(ledPulse),
    .irqLineSel(irqLineSel), .runCmd(runCmd), .chanGroups(chanGroups),
    .singleEnded(singleEnded), .inputRange2x(inputRange2x), .pacing(pacing),
    .irqThreshold(irqThreshold), .irqEnable(irqEnable)
  );

  // Fields: {rd, wr, addr[9:0], lanes[1:0], wdata[15:0], expRd[15:0], expPop, expLed}
  localparam int NV = 19;
  localparam logic [47:0] VECS [NV] = '{
    {1'b1, 1'b0, 10'h100, 2'b11, 16'h0000, 16'h013F, 1'b0, 1'b0},
    {1'b0, 1'b1, 10'h102, 2'b11, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h102, 2'b11, 16'h0000, 16'h01FF, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h103, 2'b10, 16'h0000, 16'h0100, 1'b0, 1'b0},
    {1'b0, 1'b1, 10'h104, 2'b11, 16'hABCD, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h104, 2'b11, 16'h0000, 16'h00CD, 1'b0, 1'b0},
    {1'b0, 1'b1, 10'h106, 2'b11, 16'h1234, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h106, 2'b11, 16'h0000, 16'h1234, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h108, 2'b11, 16'h0000, 16'h4B0E, 1'b0, 1'b0},
    {1'b0, 1'b1, 10'h108, 2'b11, 16'hFFC1, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h108, 2'b11, 16'h0000, 16'h4B0F, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h10A, 2'b11, 16'h0000, 16'hA5C3, 1'b1, 1'b1},
    {1'b1, 1'b0, 10'h11A, 2'b01, 16'h0000, 16'h00C3, 1'b0, 1'b1},
    {1'b1, 1'b0, 10'h11B, 2'b10, 16'h0000, 16'hA500, 1'b1, 1'b1},
    {1'b0, 1'b1, 10'h10C, 2'b11, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h10C, 2'b11, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h120, 2'b11, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 10'h122, 2'b11, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 10'h102, 2'b11, 16'h0000, 16'h01FF, 1'b0, 1'b0}
  };

  function automatic string vecReq(input int i);
    if (i == 0)       return "R2";
    else if (i <= 7)  return "R3";
    else if (i <= 10) return "R6";
    else if (i <= 13) return "R5";
    else if (i <= 15) return "R10";
    else              return "R1";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic rd, input logic wr, input logic [9:0] a,
                          input logic [1:0] be, input logic [15:0] wd);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busByteEn = be; busWrData = wd;
    #2;
    popSeen = fifoPop;
    ledSeen = ledPulse;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    busCycle(1'b0, 1'b0, 10'h000, 2'b00, 16'h0000);
  endtask

  task automatic wrWord(input logic [9:0] a, input logic [15:0] wd);
    busCycle(1'b0, 1'b1, a, 2'b11, wd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2;
    // Values right after reset
    check("R12 reset rdData", 32'(busRdData), 32'h0);
    check("R7 reset singleEnded", 32'(singleEnded), 32'h1);
    check("R8 reset inputRange2x", 32'(inputRange2x), 32'h1);
    check("R6 reset threshold", 32'(irqThreshold), 32'd256);
    check("R6 reset irqEnable", 32'(irqEnable), 32'h0);
    check("R3 reset pacing", 32'(pacing), 32'h0);
    check("R3 reset runCmd", 32'(runCmd), 32'h0);
    check("R11 irqLineSel low", 32'(irqLineSel), 32'h0);

    for (int i = 0; i < NV; i++) begin
      busCycle(VECS[i][47], VECS[i][46], VECS[i][45:36], VECS[i][35:34], VECS[i][33:18]);
      check({vecReq(i), " table rdData"}, 32'(busRdData), 32'(VECS[i][17:2]));
      check("R5 table fifoPop", 32'(popSeen), 32'(VECS[i][1]));
      check("R9 table ledPulse", 32'(ledSeen), 32'(VECS[i][0]));
    end
    idle();
    check("R3 runCmd after 0xFFFF", 32'(runCmd), 32'h1);
    check("R3 chanGroups after 0xFFFF", 32'(chanGroups), 32'hF);
    check("R6 threshold after write", 32'(irqThreshold), 32'h3FF);
    check("R6 irqEnable after write", 32'(irqEnable), 32'h1);
    check("R12 idle rdData", 32'(busRdData), 32'h0);

    // R4: split writes
    busCycle(1'b0, 1'b1, 10'h106, 2'b01, 16'h0077);
    check("R4 low byte alone holds", 32'(pacing), 32'hCD1234);
    busCycle(1'b0, 1'b1, 10'h107, 2'b10, 16'h5500);
    check("R4 pair commit", 32'(pacing), 32'hCD5577);
    busCycle(1'b0, 1'b1, 10'h106, 2'b01, 16'h0011);
    idle();
    busCycle(1'b0, 1'b1, 10'h107, 2'b10, 16'h2200);
    check("R4 gap discards", 32'(pacing), 32'hCD5577);
    busCycle(1'b0, 1'b1, 10'h107, 2'b10, 16'h9900);
    check("R4 lone high ignored", 32'(pacing), 32'hCD5577);
    busCycle(1'b0, 1'b1, 10'h106, 2'b01, 16'h0033);
    busCycle(1'b0, 1'b1, 10'h105, 2'b10, 16'h4400);
    check("R4 other register discards", 32'(pacing), 32'hCD5577);
    busCycle(1'b0, 1'b1, 10'h104, 2'b01, 16'h0012);
    busCycle(1'b0, 1'b1, 10'h105, 2'b10, 16'h3400);
    check("R4 pair to upper pacing", 32'(pacing), 32'h125577);
    busCycle(1'b1, 1'b0, 10'h104, 2'b11, 16'h0000);
    check("R3 upper pacing high byte zero", 32'(busRdData), 32'h0012);

    // R7, R8: mode decode
    wrWord(10'h102, 16'h0000);
    check("R7 both clear", 32'(singleEnded), 32'h0);
    check("R8 range 00", 32'(inputRange2x), 32'h0);
    check("R3 runCmd clear", 32'(runCmd), 32'h0);
    wrWord(10'h102, 16'h0020);
    check("R7 bit5 only", 32'(singleEnded), 32'h1);
    wrWord(10'h102, 16'h0100);
    check("R7 bit8 only", 32'(singleEnded), 32'h1);
    check("R8 range 00 again", 32'(inputRange2x), 32'h0);
    wrWord(10'h102, 16'h0040);
    check("R8 range 01", 32'(inputRange2x), 32'h1);
    wrWord(10'h102, 16'h0080);
    check("R8 range 10", 32'(inputRange2x), 32'h1);
    wrWord(10'h102, 16'h000B);
    check("R3 chanGroups 5", 32'(chanGroups), 32'h5);
    check("R3 runCmd set", 32'(runCmd), 32'h1);

    // R6: a status write leaves the count alone
    wrWord(10'h108, 16'h0C80);
    check("R6 threshold 50", 32'(irqThreshold), 32'd50);
    check("R6 enable cleared", 32'(irqEnable), 32'h0);
    busCycle(1'b1, 1'b0, 10'h108, 2'b11, 16'h0000);
    check("R6 count unchanged", 32'(busRdData), 32'h4B0E);

    // R1: a misaligned lane is ignored
    busCycle(1'b1, 1'b0, 10'h10B, 2'b01, 16'h0000);
    check("R1 misaligned no pop", 32'(popSeen), 32'h0);
    check("R1 misaligned reads zero", 32'(busRdData), 32'h0);

    // R1, R2, R11: jumper-selected windows
    jumpers = 4'b1011;
    busCycle(1'b1, 1'b0, 10'h160, 2'b11, 16'h0000);
    check("R2 id at 0x160", 32'(busRdData), 32'hB13F);
    check("R11 irqLineSel high", 32'(irqLineSel), 32'h1);
    busCycle(1'b1, 1'b0, 10'h100, 2'b11, 16'h0000);
    check("R1 old window gone", 32'(busRdData), 32'h0);
    jumpers = 4'b0001;
    busCycle(1'b1, 1'b0, 10'h120, 2'b11, 16'h0000);
    check("R1 window 0x120", 32'(busRdData), 32'h113F);
    jumpers = 4'b0010;
    busCycle(1'b1, 1'b0, 10'h140, 2'b11, 16'h0000);
    check("R1 window 0x140", 32'(busRdData), 32'h213F);
    check("R11 irqLineSel low again", 32'(irqLineSel), 32'h0);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule